// File: doc/BRIEF.md
# Low-Power Mode Controller for a Two-Channel Load Switch

This block decides when a two-channel high-side switch may drop into a manually requested low-quiescent-current mode, and how it leaves that mode again. A controller asks for the mode by writing a request bit of 1. The block accepts the request only when the entry precondition flag is true. It raises the mode status at once and then, after a fixed entry delay, moves every enabled channel from its large output transistor to its small one.

While the mode is held, the block watches per-channel current codes. A current above the channel's selected wake threshold returns the device to full operation and drives a timed active-low wake pulse. A current above the low-power short-circuit threshold switches that channel's small transistor off, waits for a retry delay, and then brings all channels back on the large transistors, again with a wake pulse. An overcurrent fault is latched only when the overcurrent is still present once the block is in full operation.

A write of 0 also ends the mode. A parameter selects one of two variants. In variant A that write enables the channels marked for auto-exit. In variant B the auto-exit bits have no effect, and any change of level on the two digital inputs also ends the mode. The current codes are in units of 10 mA.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset, mode status is 0, the wake output is 1, the fault flag is 0, and all transistor enables and channel enables are 0.
- R2: A write of request 1 while the entry precondition is 0 leaves mode status at 0 and clears the request bit, so a later write of 1 with the precondition true is accepted.
- R3: An accepted entry sets mode status in the cycle after the write. The channels stay on their large transistors for ENTRY_CYC cycles in total and then switch.
- R4: In low-power mode each enabled channel has its small transistor on and its large transistor off. No channel ever has both on.
- R5: A write of request 0 while mode status is 1 clears mode status in the next cycle without a wake pulse, and the enabled channels return to their large transistors.
- R6: On that exit write, variant A enables every channel whose auto-exit bit is 1 (the write's own channel-enable field ORed with its auto-exit field). Variant B ignores the auto-exit bits.
- R7: In variant B, any level change on din while in low-power mode ends the mode on the next clock. Variant A ignores din.
- R8: An enabled channel current above its wake threshold ends low-power mode on the next clock. The wake output is then low for exactly WAKE_CYC cycles, with both channels on their large transistors.
- R9: The wake threshold select is 2 bits per channel (bits [1:0] for channel 0, [3:2] for channel 1), encoded 00 = 53 (reset default), 01 = 70, 10 = 17, 11 = 35. The comparison is strictly greater than.
- R10: In low-power mode, an enabled channel current above 120 turns only that channel's small transistor off and ends the mode. After RETRY_CYC cycles both enabled channels run on their large transistors and the wake output pulses low.
- R11: The fault flag is set when an enabled channel's current exceeds 200 while the block is in full operation (including the wake pulse). It is never set in low-power or retry phases, and it stays set until reset.
- R12: After a current-triggered exit the request bit stays 1, and a further write of 1 does not re-enter. A write of 0 followed by a write of 1 re-enters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_lpm_req | input | 1 | Low-power request bit of the write |
| wr_auto_exit | input | 2 | Per-channel auto-exit enable bits |
| wr_wake_sel | input | 4 | Per-channel wake threshold select |
| wr_ch_en | input | 2 | Per-channel enable field |
| ch_cur | input | 2*CW | Current codes, channel 0 in the low CW bits |
| din | input | 2 | Digital input pins |
| entry_ok | input | 1 | Entry precondition satisfied |
| lpm_status | output | 1 | Mode status bit |
| wake_n | output | 1 | Active-low wake/fault pulse |
| small_fet_en | output | 2 | Small transistor enable per channel |
| large_fet_en | output | 2 | Large transistor enable per channel |
| ch_en | output | 2 | Channel enable per channel |
| ocp_fault | output | 1 | Latched overcurrent fault |

## Verification
The assertions check several rules on every cycle. The two transistors of a channel are never both on. A wake pulse never overlaps low-power status or a small-transistor drive. A rejected or repeated write of 1 never raises status, and an exit write always drops it. A newly raised fault always follows a cycle in full operation. The shared counter only steps down by one. Other behaviour can only be shown by the bench's scenarios: the exact entry, retry and wake-pulse lengths, the non-monotonic threshold encoding at its strict boundaries, the variant differences for auto-exit and digital-input exit, the selective turn-off on a short circuit, and the 0-then-1 re-entry rule.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    typedef enum logic [2:0] {
        ST_ACT,
        ST_ENTER,
        ST_LPM,
        ST_RETRY,
        ST_WAKE
    } lpm_state_e;

    localparam int unsigned DEF_TH_SEL0 = 53;
    localparam int unsigned DEF_TH_SEL1 = 70;
    localparam int unsigned DEF_TH_SEL2 = 17;
    localparam int unsigned DEF_TH_SEL3 = 35;
    localparam int unsigned DEF_TH_SCP  = 120;
    localparam int unsigned DEF_TH_OCP  = 200;
endpackage

// File: rtl/lpm_thresh.sv
module lpm_thresh #(
    parameter int unsigned CW      = 8,
    parameter int unsigned TH_SEL0 = 53,
    parameter int unsigned TH_SEL1 = 70,
    parameter int unsigned TH_SEL2 = 17,
    parameter int unsigned TH_SEL3 = 35,
    parameter int unsigned TH_SCP  = 120,
    parameter int unsigned TH_OCP  = 200
) (
    input  logic [CW-1:0] cur,
    input  logic [1:0]    sel,
    output logic          over_wake,
    output logic          over_scp,
    output logic          over_ocp
);
    logic [CW-1:0] wake_th;

    always_comb begin
        unique case (sel)
            2'b00:   wake_th = CW'(TH_SEL0);
            2'b01:   wake_th = CW'(TH_SEL1);
            2'b10:   wake_th = CW'(TH_SEL2);
            default: wake_th = CW'(TH_SEL3);
        endcase
    end

    assign over_wake = cur > wake_th;
    assign over_scp  = cur > CW'(TH_SCP);
    assign over_ocp  = cur > CW'(TH_OCP);
endmodule

// File: rtl/lpm_timer.sv
module lpm_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R3: delay windows shrink by exactly one per cycle
    a_r3_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter bit          VARIANT_B = 1'b0,
    parameter int unsigned CW        = 8,
    parameter int unsigned ENTRY_CYC = 16,
    parameter int unsigned WAKE_CYC  = 32,
    parameter int unsigned RETRY_CYC = 24,
    parameter int unsigned TH_SEL0   = DEF_TH_SEL0,
    parameter int unsigned TH_SEL1   = DEF_TH_SEL1,
    parameter int unsigned TH_SEL2   = DEF_TH_SEL2,
    parameter int unsigned TH_SEL3   = DEF_TH_SEL3,
    parameter int unsigned TH_SCP    = DEF_TH_SCP,
    parameter int unsigned TH_OCP    = DEF_TH_OCP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_lpm_req,
    input  logic [1:0]       wr_auto_exit,
    input  logic [3:0]       wr_wake_sel,
    input  logic [1:0]       wr_ch_en,
    input  logic [2*CW-1:0]  ch_cur,
    input  logic [1:0]       din,
    input  logic             entry_ok,
    output logic             lpm_status,
    output logic             wake_n,
    output logic [1:0]       small_fet_en,
    output logic [1:0]       large_fet_en,
    output logic [1:0]       ch_en,
    output logic             ocp_fault
);
    localparam int unsigned NCH   = 2;
    localparam int unsigned MAXD0 = (ENTRY_CYC > WAKE_CYC) ? ENTRY_CYC : WAKE_CYC;
    localparam int unsigned MAXD  = (MAXD0 > RETRY_CYC) ? MAXD0 : RETRY_CYC;
    localparam int unsigned TW    = $clog2(MAXD + 1);

    typedef struct packed {
        lpm_state_e       st;
        logic             req;
        logic [NCH-1:0]   auto_ex;
        logic [2*NCH-1:0] wsel;
        logic [NCH-1:0]   en;
        logic [NCH-1:0]   sc_mask;
        logic [1:0]       din_prev;
        logic             ocp;
    } ctrl_s;

    ctrl_s q, d;

    logic [NCH-1:0] ovr_wake, ovr_scp, ovr_ocp;
    logic           tmr_load, tmr_zero;
    logic [TW-1:0]  tmr_val;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        lpm_thresh #(
            .CW(CW), .TH_SEL0(TH_SEL0), .TH_SEL1(TH_SEL1), .TH_SEL2(TH_SEL2),
            .TH_SEL3(TH_SEL3), .TH_SCP(TH_SCP), .TH_OCP(TH_OCP)
        ) u_th (
            .cur       (ch_cur[c*CW +: CW]),
            .sel       (q.wsel[2*c +: 2]),
            .over_wake (ovr_wake[c]),
            .over_scp  (ovr_scp[c]),
            .over_ocp  (ovr_ocp[c])
        );
    end

    lpm_timer #(.TW(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    logic [NCH-1:0] sc_hit, wk_hit;
    logic           full_op, exit_wr, start;
    assign sc_hit  = ovr_scp & q.en;
    assign wk_hit  = ovr_wake & q.en;
    assign full_op = (q.st == ST_ACT) || (q.st == ST_WAKE);

    always_comb begin
        d        = q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        exit_wr  = 1'b0;
        start    = 1'b0;
        d.din_prev = din;
        if (wr_en) begin
            d.wsel    = wr_wake_sel;
            d.auto_ex = wr_auto_exit;
            d.en      = wr_ch_en;
            d.req     = wr_lpm_req;
        end
        if (full_op && |(ovr_ocp & q.en))
            d.ocp = 1'b1;
        unique case (q.st)
            ST_ACT: begin
                if (wr_en && wr_lpm_req && !q.req && entry_ok) begin
                    start    = 1'b1;
                    d.st     = ST_ENTER;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(ENTRY_CYC - 1);
                end
            end
            ST_ENTER: begin
                if (wr_en && !wr_lpm_req) begin
                    d.st    = ST_ACT;
                    exit_wr = 1'b1;
                end else if (tmr_zero) begin
                    d.st = ST_LPM;
                end
            end
            ST_LPM: begin
                if (wr_en && !wr_lpm_req) begin
                    d.st    = ST_ACT;
                    exit_wr = 1'b1;
                end else if (|sc_hit) begin
                    d.st      = ST_RETRY;
                    d.sc_mask = sc_hit;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(RETRY_CYC - 1);
                end else if (|wk_hit) begin
                    d.st     = ST_WAKE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(WAKE_CYC - 1);
                end else if (VARIANT_B && (din != q.din_prev)) begin
                    d.st = ST_ACT;
                end
            end
            ST_RETRY: begin
                if (tmr_zero) begin
                    d.st      = ST_WAKE;
                    d.sc_mask = '0;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(WAKE_CYC - 1);
                end
            end
            default: begin
                if (tmr_zero) d.st = ST_ACT;
            end
        endcase
        // rejected first request: bit falls back to 0
        if (wr_en && wr_lpm_req && !q.req && !start)
            d.req = 1'b0;
        if (exit_wr && !VARIANT_B)
            d.en = d.en | d.auto_ex;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st       <= ST_ACT;
            q.req      <= 1'b0;
            q.auto_ex  <= '0;
            q.wsel     <= '0;
            q.en       <= '0;
            q.sc_mask  <= '0;
            q.din_prev <= '0;
            q.ocp      <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign lpm_status   = (q.st == ST_ENTER) || (q.st == ST_LPM);
    assign wake_n       = (q.st != ST_WAKE);
    assign small_fet_en = (q.st == ST_LPM)   ? q.en :
                          (q.st == ST_RETRY) ? (q.en & ~q.sc_mask) : '0;
    assign large_fet_en = (full_op || q.st == ST_ENTER) ? q.en : '0;
    assign ch_en        = q.en;
    assign ocp_fault    = q.ocp;

    // R4: a channel never drives both transistors
    a_r4_fet_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (small_fet_en & large_fet_en) == '0);
    // R2: rejected entry never raises status
    a_r2_reject_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_lpm_req && !entry_ok && !lpm_status) |=> !lpm_status);
    // R3: status rises before any small transistor is used
    a_r3_status_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lpm_status) |-> (small_fet_en == '0));
    // R5: exit write drops status with no pulse
    a_r5_manual_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (lpm_status && wr_en && !wr_lpm_req) |=> (!lpm_status && wake_n));
    // R8: wake pulse only in full operation
    a_r8_pulse_active: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_n |-> (!lpm_status && small_fet_en == '0));
    // R12: request still 1 after current exit blocks re-entry
    a_r12_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
        (q.req && q.st == ST_ACT && wr_en && wr_lpm_req) |=> !lpm_status);
    // R11: a new fault follows a cycle in full operation
    a_r11_fault_active: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ocp_fault) |-> ($past(small_fet_en) == '0 && !$past(lpm_status)));
endmodule

// File: tb/sim_lpm_ctrl.sv
module sim_lpm_ctrl;
    localparam int unsigned CW = 8;
    localparam int unsigned EC = 4;
    localparam int unsigned WC = 5;
    localparam int unsigned RC = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic            wr_en = 0, wr_lpm_req = 0, entry_ok = 0;
    logic [1:0]      wr_auto_exit = 0, wr_ch_en = 0, din = 0;
    logic [3:0]      wr_wake_sel = 0;
    logic [2*CW-1:0] ch_cur = 0;

    logic       st_a, wk_a, f_a, st_b, wk_b, f_b;
    logic [1:0] sm_a, lg_a, en_a, sm_b, lg_b, en_b;

    lpm_ctrl #(.VARIANT_B(1'b0), .CW(CW), .ENTRY_CYC(EC), .WAKE_CYC(WC), .RETRY_CYC(RC)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_lpm_req(wr_lpm_req),
        .wr_auto_exit(wr_auto_exit), .wr_wake_sel(wr_wake_sel), .wr_ch_en(wr_ch_en),
        .ch_cur(ch_cur), .din(din), .entry_ok(entry_ok),
        .lpm_status(st_a), .wake_n(wk_a), .small_fet_en(sm_a), .large_fet_en(lg_a),
        .ch_en(en_a), .ocp_fault(f_a));

    lpm_ctrl #(.VARIANT_B(1'b1), .CW(CW), .ENTRY_CYC(EC), .WAKE_CYC(WC), .RETRY_CYC(RC)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_lpm_req(wr_lpm_req),
        .wr_auto_exit(wr_auto_exit), .wr_wake_sel(wr_wake_sel), .wr_ch_en(wr_ch_en),
        .ch_cur(ch_cur), .din(din), .entry_ok(entry_ok),
        .lpm_status(st_b), .wake_n(wk_b), .small_fet_en(sm_b), .large_fet_en(lg_b),
        .ch_en(en_b), .ocp_fault(f_b));

    int n_chk = 0;
    int n_fail = 0;
    logic [3:0] sel_cfg = 4'b0000;

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic req, input logic [1:0] au, input logic [1:0] en);
        @(negedge clk);
        wr_en = 1; wr_lpm_req = req; wr_auto_exit = au; wr_wake_sel = sel_cfg; wr_ch_en = en;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic enter_lpm();
        ch_cur = '0;
        do_wr(0, 2'b00, 2'b11);
        do_wr(1, 2'b00, 2'b11);
        repeat (EC) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(st_a, 0, "R1 status");
        chk(wk_a, 1, "R1 wake_n");
        chk(f_a, 0, "R1 fault");
        chk({sm_a, lg_a, en_a}, 0, "R1 enables");
    endtask

    task automatic t_entry();
        entry_ok = 0;
        do_wr(1, 2'b00, 2'b11);
        chk(st_a, 0, "R2 rejected status");
        chk(st_b, 0, "R2 rejected status B");
        entry_ok = 1;
        do_wr(1, 2'b00, 2'b11);
        chk(st_a, 1, "R2 later accept / R3 status first");
        chk(lg_a, 3, "R3 large during entry");
        repeat (EC - 1) @(negedge clk);
        chk(lg_a, 3, "R3 large at last entry cycle");
        chk(sm_a, 0, "R3 small off at last entry cycle");
        @(negedge clk);
        chk(sm_a, 3, "R4 small on");
        chk(lg_a, 0, "R4 large off");
        chk(sm_b, 3, "R4 small on B");
    endtask

    task automatic t_din_and_exit();
        @(negedge clk) din = 2'b01;
        @(negedge clk);
        chk(st_b, 0, "R7 variant B din exit");
        chk(lg_b, 3, "R7 variant B large on");
        chk(st_a, 1, "R7 variant A ignores din");
        do_wr(0, 2'b01, 2'b00);
        chk(st_a, 0, "R5 exit status");
        chk(wk_a, 1, "R5 no pulse");
        chk(lg_a, 1, "R5 large back on");
        chk(en_a, 1, "R6 variant A auto-exit enable");
        chk(en_b, 0, "R6 variant B ignores auto-exit");
        do_wr(0, 2'b00, 2'b11);
    endtask

    task automatic t_wake();
        int lows;
        sel_cfg = 4'b0000;
        enter_lpm();
        @(negedge clk) ch_cur = {8'd0, 8'd50};
        repeat (3) @(negedge clk);
        chk(st_a, 1, "R9 below default threshold");
        ch_cur = {8'd0, 8'd54};
        @(negedge clk);
        chk(wk_a, 0, "R8 pulse starts");
        chk(st_a, 0, "R8 status cleared");
        chk(lg_a, 3, "R8 large on");
        lows = 1;
        for (int i = 0; i < WC + 2; i++) begin
            @(negedge clk);
            if (wk_a == 0) lows++;
        end
        chk(lows, WC, "R8 pulse length");
        chk(wk_b, 1, "R8 pulse ended B");
        ch_cur = '0;
        do_wr(1, 2'b00, 2'b11);
        chk(st_a, 0, "R12 repeated 1 ignored");
        repeat (EC + 1) @(negedge clk);
        chk(st_a, 0, "R12 still active");
        enter_lpm();
        chk(st_a, 1, "R12 0-then-1 re-entry");
        chk(sm_a, 3, "R12 small on after re-entry");
    endtask

    task automatic try_wake(input logic [3:0] sel, input logic [7:0] c0, input logic [7:0] c1,
                            input int exp_wake, input string tag);
        sel_cfg = sel;
        enter_lpm();
        @(negedge clk) ch_cur = {c1, c0};
        @(negedge clk);
        chk(!st_a, exp_wake, tag);
        ch_cur = '0;
        repeat (WC + 2) @(negedge clk);
    endtask

    task automatic t_thresholds();
        try_wake(4'b0000, 8'd53, 8'd0, 0, "R9 sel00 at 53");
        try_wake(4'b0001, 8'd70, 8'd0, 0, "R9 sel01 at 70");
        try_wake(4'b0001, 8'd71, 8'd0, 1, "R9 sel01 at 71");
        try_wake(4'b1000, 8'd0,  8'd17, 0, "R9 sel10 ch1 at 17");
        try_wake(4'b1000, 8'd0,  8'd18, 1, "R9 sel10 ch1 at 18");
        try_wake(4'b0011, 8'd35, 8'd0, 0, "R9 sel11 at 35");
        try_wake(4'b0011, 8'd36, 8'd0, 1, "R9 sel11 at 36");
        sel_cfg = 4'b0000;
    endtask

    task automatic t_short();
        enter_lpm();
        @(negedge clk) ch_cur = {8'd130, 8'd0};
        @(negedge clk);
        chk(sm_a, 1, "R10 only ch1 small off");
        chk(lg_a, 0, "R10 large off during retry");
        chk(st_a, 0, "R10 status cleared");
        repeat (RC - 1) @(negedge clk);
        chk(sm_a, 1, "R10 retry window held");
        @(negedge clk);
        chk(lg_a, 3, "R10 large after retry");
        chk(wk_a, 0, "R10 wake pulse after retry");
        repeat (WC + 2) @(negedge clk);
        chk(f_a, 0, "R11 no fault below 200");
        ch_cur = '0;
    endtask

    task automatic t_ocp();
        enter_lpm();
        @(negedge clk) ch_cur = {8'd0, 8'd210};
        @(negedge clk);
        chk(f_a, 0, "R11 no fault in retry");
        repeat (RC) @(negedge clk);
        chk(f_a, 0, "R11 no fault before active check");
        @(negedge clk);
        chk(f_a, 1, "R11 fault confirmed in active");
        ch_cur = '0;
        repeat (3) @(negedge clk);
        chk(f_a, 1, "R11 fault sticky");
    endtask

    initial begin
        #40000;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_entry();
        t_din_and_exit();
        t_wake();
        t_thresholds();
        t_short();
        t_ocp();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule